// File: doc/BRIEF.md
# Timestamped Event Capture Controller

This block collects a stream of bus events into an on-chip buffer so a host can read them out later. An event is either a data byte or a change on the status lines. Each stored event becomes one 24-bit entry made of three parts: a one-bit kind tag, the 8-bit payload, and a 15-bit count of clock cycles since the previous stored event.

Recording is armed by software and then waits for a start pulse from the trigger logic. After that pulse a programmable hold-off runs before the capture window opens. The window closes once the programmed number of events has been stored. A programmed count of zero leaves the window open until the buffer fills.

The host drains the buffer through a first-word-fall-through read port. It can watch an occupancy-above-threshold flag to decide when a burst read is worth starting. Two sticky error flags report trouble. The overflow flag is set when a write is refused because the buffer is full. The underflow flag is set when a read is attempted on an empty buffer.

Top module: `evcap_ctrl`

## Requirements
- R1: After reset the buffer reports empty, the threshold, overflow and underflow flags are low and `armed` is low.
- R2: A pulse on `arm` makes `armed` high on the next cycle. A `start` pulse that arrives while the block is not waiting for one is ignored. An event offered while the capture window is closed is not stored, so the buffer stays unchanged.
- R3: If `start` is sampled at clock edge k and the delay register holds D, the first edge that can store an event is edge k+D+1.
- R4: With a nonzero size N, the window closes at the edge that stores the N-th event, and `armed` is low after that edge. Events offered after that edge are not stored. With a size of zero, there is no event limit.
- R5: Entry layout is as follows. Bit 23 is the kind tag, 1 for a status event and 0 for a data event. Bits 22:15 hold the payload. Bits 14:0 hold the timestamp, which saturates at 32767. For the first event, the timestamp is the number of edges since the window opened, so an event on the first window edge reads 0. For every later event, it is the number of edges since the previous stored event.
- R6: Entries are read back in arrival order. `rd_data` shows the oldest entry whenever the buffer is not empty. A read pulse removes that entry at the next edge.
- R7: `fifo_over_thr` is high exactly when more than 128 entries are held.
- R8: If an event is offered while all 1024 entries are full, the write is refused and the stored contents remain intact. `fifo_overflow` sets and stays set. The window closes and `armed` goes low.
- R9: A read while the buffer is empty sets the sticky `fifo_underflow`, and the occupancy stays zero.
- R10: An `arm` pulse clears both error flags and the stored-event count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Arm pulse; clears errors and count |
| start | input | 1 | Start pulse from trigger logic |
| cfg_delay | input | 18 | Hold-off in cycles after start |
| cfg_size | input | 24 | Events to store, 0 for no limit |
| ev_valid | input | 1 | Event present this cycle |
| ev_is_stat | input | 1 | Event is a status change |
| ev_data | input | 8 | Event payload |
| rd_en | input | 1 | Host read pulse |
| rd_data | output | 24 | Oldest stored entry |
| fifo_empty | output | 1 | Buffer holds no entries |
| fifo_over_thr | output | 1 | More than 128 entries held |
| fifo_overflow | output | 1 | Sticky refused-write flag |
| fifo_underflow | output | 1 | Sticky empty-read flag |
| armed | output | 1 | Waiting, holding off or capturing |

## Verification
An event offered in the window is written at the edge where it is sampled. The empty and threshold flags, the overflow flag and the `armed` drop all change at that same edge. The bench therefore reads them shortly after that edge and before it drives the next input. `rd_data` is a combinational view of the head, so each entry is compared before the read pulse is driven, and the next one is compared one edge later. The hold-off is checked by offering events on every cycle from the start edge onward. Only those from edge k+D+1 onward may appear in the model queue, and the queue is compared in full at drain time.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DELAY = 2'd2,
    ST_CAPT  = 2'd3
  } evcap_state_e;

  typedef enum logic {
    KIND_DATA = 1'b0,
    KIND_STAT = 1'b1
  } evcap_kind_e;

endpackage

// File: rtl/evcap_sequencer.sv
module evcap_sequencer
  import evcap_pkg::*;
#(
  parameter int DLY_W = 18,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             start_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [CNT_W-1:0] size_i,
  input  logic             wr_done_i,
  input  logic             wr_block_i,
  output logic             capt_o,
  output logic             armed_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

  evcap_state_e     st_q, st_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             limit_hit;

  assign cnt_inc   = cnt_q + CNT_ONE;
  assign limit_hit = (size_i != '0) && (cnt_inc == size_i);

  always_comb begin
    st_d  = st_q;
    dly_d = dly_q;
    cnt_d = cnt_q;
    if (arm_i) begin
      st_d  = ST_WAIT;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_WAIT: begin
          if (start_i) begin
            if (delay_i == '0) begin
              st_d = ST_CAPT;
            end else begin
              st_d  = ST_DELAY;
              dly_d = delay_i - DLY_ONE;
            end
          end
        end
        ST_DELAY: begin
          if (dly_q == '0) st_d = ST_CAPT;
          else             dly_d = dly_q - DLY_ONE;
        end
        ST_CAPT: begin
          if (wr_block_i) begin
            st_d = ST_IDLE;
          end else if (wr_done_i) begin
            cnt_d = cnt_inc;
            if (limit_hit) st_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dly_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      dly_q <= dly_d;
      cnt_q <= cnt_d;
    end
  end

  assign capt_o  = (st_q == ST_CAPT);
  assign armed_o = (st_q != ST_IDLE);

endmodule

// File: rtl/evcap_stamper.sv
module evcap_stamper
  import evcap_pkg::*;
#(
  parameter int PAYLOAD_W = 8,
  parameter int TS_W      = 15
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        capt_i,
  input  logic                        ev_valid_i,
  input  logic                        ev_is_stat_i,
  input  logic [PAYLOAD_W-1:0]        ev_data_i,
  output logic [1+PAYLOAD_W+TS_W-1:0] entry_o
);

  localparam logic [TS_W-1:0] TS_MAX = {TS_W{1'b1}};
  localparam logic [TS_W-1:0] TS_ONE = TS_W'(1);

  logic [TS_W-1:0] ts_q, ts_d;
  evcap_kind_e     kind;

  always_comb begin
    if (!capt_i)          ts_d = '0;
    else if (ev_valid_i)  ts_d = TS_ONE;
    else if (ts_q == TS_MAX) ts_d = TS_MAX;
    else                  ts_d = ts_q + TS_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_d;
  end

  assign kind    = ev_is_stat_i ? KIND_STAT : KIND_DATA;
  assign entry_o = {kind, ev_data_i, ts_q};

endmodule

// File: rtl/evcap_fifo.sv
module evcap_fifo #(
  parameter int WIDTH  = 24,
  parameter int DEPTH  = 1024,
  parameter int THRESH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             over_thr_o,
  output logic             overflow_o,
  output logic             underflow_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] PTR_ONE  = AW'(1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_THR  = CW'(THRESH);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ovf_q, ovf_d, unf_q, unf_d;
  logic             push, pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_FULL);
  assign push    = wr_i && !full_o;
  assign pop     = rd_i && !empty_o;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + PTR_ONE;
    if (pop)  rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + PTR_ONE;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CNT_ONE;
      2'b01:   cnt_d = cnt_q - CNT_ONE;
      default: ;
    endcase
    if (clr_i) begin
      ovf_d = 1'b0;
      unf_d = 1'b0;
    end else begin
      ovf_d = ovf_q || (wr_i && full_o);
      unf_d = unf_q || (rd_i && empty_o);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wdata_i;
  end

  assign rdata_o     = mem[rptr_q];
  assign over_thr_o  = (cnt_q > CNT_THR);
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

endmodule

// File: rtl/evcap_ctrl.sv
module evcap_ctrl #(
  parameter int PAYLOAD_W = 8,
  parameter int TS_W      = 15,
  parameter int DLY_W     = 18,
  parameter int CNT_W     = 24,
  parameter int DEPTH     = 1024,
  parameter int THRESH    = 128,
  parameter int ENTRY_W   = 1 + PAYLOAD_W + TS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic                 start,
  input  logic [DLY_W-1:0]     cfg_delay,
  input  logic [CNT_W-1:0]     cfg_size,
  input  logic                 ev_valid,
  input  logic                 ev_is_stat,
  input  logic [PAYLOAD_W-1:0] ev_data,
  input  logic                 rd_en,
  output logic [ENTRY_W-1:0]   rd_data,
  output logic                 fifo_empty,
  output logic                 fifo_over_thr,
  output logic                 fifo_overflow,
  output logic                 fifo_underflow,
  output logic                 armed
);

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic               capt, full;
  logic               wr_req, wr_done, wr_block;
  logic [ENTRY_W-1:0] entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign wr_req   = capt && ev_valid;
  assign wr_done  = wr_req && !full;
  assign wr_block = wr_req && full;

  evcap_sequencer #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .arm_i      (arm),
    .start_i    (start),
    .delay_i    (cfg_delay),
    .size_i     (cfg_size),
    .wr_done_i  (wr_done),
    .wr_block_i (wr_block),
    .capt_o     (capt),
    .armed_o    (armed)
  );

  evcap_stamper #(.PAYLOAD_W(PAYLOAD_W), .TS_W(TS_W)) u_stamp (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .capt_i       (capt),
    .ev_valid_i   (ev_valid),
    .ev_is_stat_i (ev_is_stat),
    .ev_data_i    (ev_data),
    .entry_o      (entry)
  );

  evcap_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH), .THRESH(THRESH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .clr_i       (arm),
    .wr_i        (wr_req),
    .wdata_i     (entry),
    .rd_i        (rd_en),
    .rdata_o     (rd_data),
    .empty_o     (fifo_empty),
    .full_o      (full),
    .over_thr_o  (fifo_over_thr),
    .overflow_o  (fifo_overflow),
    .underflow_o (fifo_underflow)
  );

endmodule

// File: rtl/evcap_ctrl_chk.sv
module evcap_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic rd_en,
  input logic fifo_empty,
  input logic fifo_over_thr,
  input logic fifo_overflow,
  input logic fifo_underflow,
  input logic armed
);

  a_r2_arm_sets_armed: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> armed);

  a_r2_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !rd_en) |=> $stable(fifo_empty));

  a_r7_thr_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_over_thr |-> !fifo_empty);

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_overflow && !arm) |=> fifo_overflow);

  a_r9_underflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fifo_empty && !arm) |=> (fifo_underflow && fifo_empty));

  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_underflow && !arm) |=> fifo_underflow);

  a_r10_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!fifo_overflow && !fifo_underflow));

endmodule

bind evcap_ctrl evcap_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .arm            (arm),
  .rd_en          (rd_en),
  .fifo_empty     (fifo_empty),
  .fifo_over_thr  (fifo_over_thr),
  .fifo_overflow  (fifo_overflow),
  .fifo_underflow (fifo_underflow),
  .armed          (armed)
);

// File: tb/evcap_ctrl_bench.sv
module evcap_ctrl_bench;

  localparam int DEPTH  = 1024;
  localparam int THRESH = 128;
  localparam int TS_MAX = 32767;

  logic        clk = 1'b0;
  logic        rst_n, arm, start, ev_valid, ev_is_stat, rd_en;
  logic [17:0] cfg_delay;
  logic [23:0] cfg_size;
  logic [7:0]  ev_data;
  logic [23:0] rd_data;
  logic        fifo_empty, fifo_over_thr, fifo_overflow, fifo_underflow, armed;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic [23:0] exp_q[$];

  always #10 clk = ~clk;

  evcap_ctrl u_evcap_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .start(start),
    .cfg_delay(cfg_delay), .cfg_size(cfg_size),
    .ev_valid(ev_valid), .ev_is_stat(ev_is_stat), .ev_data(ev_data),
    .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty),
    .fifo_over_thr(fifo_over_thr), .fifo_overflow(fifo_overflow),
    .fifo_underflow(fifo_underflow), .armed(armed)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mk_entry(input bit stat, input logic [7:0] d, input int gap);
    int t;
    t = (gap > TS_MAX) ? TS_MAX : gap;
    return {stat, d, 15'(t)};
  endfunction

  task automatic do_arm();
    arm = 1'b1;
    tick();
    arm = 1'b0;
    chk(armed === 1'b1, "R2 armed after arm", armed, 1);
    chk(fifo_overflow === 1'b0 && fifo_underflow === 1'b0, "R10 flags cleared",
        {fifo_overflow, fifo_underflow}, 0);
  endtask

  // mode 0: random events, 1: every cycle, 2: two events far apart
  task automatic run_capture(input int d, input int sz, input int mode, input int max_cyc);
    int  stored = 0;
    int  prev   = 0;
    bit  stop   = 1'b0;
    bit  v;
    cfg_delay = 18'(d);
    cfg_size  = 24'(sz);
    do_arm();
    ev_valid = 1'b1; ev_data = 8'hEE; ev_is_stat = 1'b0;
    tick(); tick();                       // R2: events while waiting are dropped
    start = 1'b1;
    tick();                               // start edge k
    start = 1'b0;
    for (int i = 0; i < d; i++) tick();   // R3: hold-off edges, events dropped
    for (int j = 0; j < max_cyc; j++) begin
      case (mode)
        0:       v = $urandom_range(0, 1) == 1;
        1:       v = 1'b1;
        default: v = (j == 0) || (j == 33000);
      endcase
      ev_valid   = v;
      ev_is_stat = $urandom_range(0, 1) == 1;
      ev_data    = 8'($urandom);
      tick();
      if (v) begin
        if (exp_q.size() == DEPTH) begin
          chk(fifo_overflow === 1'b1, "R8 overflow set", fifo_overflow, 1);
          stop = 1'b1;
        end else begin
          exp_q.push_back(mk_entry(ev_is_stat, ev_data, j - prev));
          prev = j;
          stored++;
          if (sz != 0 && stored == sz) stop = 1'b1;
        end
      end
      if (mode != 2 || v)
        chk(fifo_over_thr === (exp_q.size() > THRESH), "R7 threshold flag",
            fifo_over_thr, exp_q.size() > THRESH);
      if (stop) break;
    end
    if (stop) chk(armed === 1'b0, "R4/R8 window closed", armed, 0);
    ev_valid = 1'b1;
    tick(); tick();                       // R4: late events dropped
    ev_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) begin
      chk(fifo_empty === 1'b0, req, fifo_empty, 0);
      chk(rd_data === exp_q[0], req, rd_data, exp_q[0]);
      rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
      void'(exp_q.pop_front());
    end
    chk(fifo_empty === 1'b1, "R6 empty after drain", fifo_empty, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; arm = 1'b0; start = 1'b0; ev_valid = 1'b0; ev_is_stat = 1'b0;
    ev_data = '0; rd_en = 1'b0; cfg_delay = '0; cfg_size = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk(fifo_empty === 1'b1, "R1 empty", fifo_empty, 1);
    chk(fifo_over_thr === 1'b0, "R1 threshold", fifo_over_thr, 0);
    chk(fifo_overflow === 1'b0 && fifo_underflow === 1'b0, "R1 errors",
        {fifo_overflow, fifo_underflow}, 0);
    chk(armed === 1'b0, "R1 armed", armed, 0);

    // R2 start and events while idle are ignored
    start = 1'b1; ev_valid = 1'b1;
    tick();
    start = 1'b0;
    tick(); tick();
    ev_valid = 1'b0;
    chk(armed === 1'b0, "R2 start ignored", armed, 0);
    chk(fifo_empty === 1'b1, "R2 idle events dropped", fifo_empty, 1);

    // R3 R4 R5 R6 directed: zero delay, five events back to back
    run_capture(0, 5, 1, 50);
    drain("R5/R6 zero-delay entries");

    // R3 nonzero delay
    run_capture(7, 20, 0, 300);
    drain("R3 delayed entries");

    // random captures
    for (int i = 0; i < 6; i++) begin
      run_capture($urandom_range(0, 20), $urandom_range(1, 40), 0, 400);
      drain("R5/R6 random entries");
    end

    // R7 threshold crossing at 129 entries
    run_capture(1, THRESH + 1, 1, THRESH + 10);
    drain("R7 threshold entries");

    // R9 underflow
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    chk(fifo_underflow === 1'b1, "R9 underflow set", fifo_underflow, 1);
    chk(fifo_empty === 1'b1, "R9 still empty", fifo_empty, 1);
    tick();
    chk(fifo_underflow === 1'b1, "R9 underflow sticky", fifo_underflow, 1);
    run_capture(2, 3, 1, 20);             // occupancy must not have gone negative
    drain("R9 count intact");

    // R4 R8 unlimited size until overflow
    run_capture(0, 0, 1, DEPTH + 10);
    tick();
    chk(fifo_overflow === 1'b1, "R8 overflow sticky", fifo_overflow, 1);
    drain("R8 contents intact");

    // R10 arm clears overflow
    do_arm();

    // R5 timestamp saturation
    run_capture(0, 2, 2, 33010);
    drain("R5 saturated timestamp");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule